// File: doc/BRIEF.md
# Serial BCD-to-Excess-3 Converter

This block converts one decimal digit at a time from BCD to excess-3 while the digit moves through it as a bit stream. The caller presents the four bits of a digit least significant bit first, one bit per cycle in which the bit-valid strobe is high. In the same cycle the block drives the matching bit of the digit plus three. The result leaves least significant bit first, with no pipeline delay. Cycles where the strobe is low are gaps: they neither advance nor disturb the digit in progress.

The conversion is a seven-state Mealy machine held in three flip-flops. Its states combine the bit position with the running carry of the add-3. The initial state carries the implied addend 0011. The machine returns to that state after every fourth valid bit. A start-of-digit output is high while the machine waits for a least significant bit, so the caller can align digit boundaries.

Top module: `bcd_xs3_serial`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) returns the machine to its initial state. After the reset, `at_lsb` is 1 and `bit_out` is 0 while `bit_vld` is low.
- R2: For a legal digit d (0 to 9) applied as four valid bits, least significant bit first, the four valid output bits, least significant bit first, form d+3.
- R3: A cycle with `bit_vld` low leaves the machine state unchanged, whatever value `bit_in` has.
- R4: After the fourth valid bit of a digit, `at_lsb` is 1 and the next valid bit is taken as a least significant bit. Between the first and fourth valid bits, `at_lsb` is 0.
- R5: `bit_out` is 0 in every cycle where `bit_vld` is low.
- R6: Each output bit appears in the same cycle as its input bit and follows that input bit combinationally. On a least significant bit, `bit_out` is the inverse of `bit_in`.
- R7: For an illegal code d (10 to 15), the output bits form (d+3) modulo 16, and the machine still returns to its initial state after four valid bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | High when `bit_in` carries a digit bit this cycle |
| bit_in | input | 1 | Serial BCD bit, least significant bit first |
| bit_out | output | 1 | Serial excess-3 bit, valid while `bit_vld` is high |
| at_lsb | output | 1 | High while the machine waits for a digit's least significant bit |

## Verification
Every result is due in the cycle of its stimulus. `bit_out` answers the current `bit_in` through combinational logic. `at_lsb` reflects the state register, so it changes one edge after the valid bit that moves it. The bench drives each input on the falling edge and compares both outputs shortly after, before the next rising edge, against a behavioural model. It then updates the model as if that rising edge had occurred. Each completed digit is also rebuilt from its four output bits and compared whole against the input plus three.

// File: rtl/bcd_xs3_serial.sv
module bcd_xs3_serial (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  output logic bit_out,
  output logic at_lsb
);

  // Position/carry states; codes chosen so P3 pair and P1 pair are adjacent.
  typedef enum logic [2:0] {
    ST_P0    = 3'b000,
    ST_P1_C0 = 3'b001,
    ST_P1_C1 = 3'b101,
    ST_P2_C0 = 3'b011,
    ST_P2_C1 = 3'b111,
    ST_P3_C0 = 3'b010,
    ST_P3_C1 = 3'b110
  } st_t;

  st_t  state, nxt;
  logic obit;

  always_comb begin
    nxt  = ST_P0;
    obit = 1'b0;
    case (state)
      ST_P0:    begin nxt = bit_in ? ST_P1_C1 : ST_P1_C0; obit = ~bit_in; end
      ST_P1_C0: begin nxt = bit_in ? ST_P2_C1 : ST_P2_C0; obit = ~bit_in; end
      ST_P1_C1: begin nxt = ST_P2_C1;                     obit =  bit_in; end
      ST_P2_C0: begin nxt = ST_P3_C0;                     obit =  bit_in; end
      ST_P2_C1: begin nxt = bit_in ? ST_P3_C1 : ST_P3_C0; obit = ~bit_in; end
      ST_P3_C0: begin nxt = ST_P0;                        obit =  bit_in; end
      ST_P3_C1: begin nxt = ST_P0;                        obit = ~bit_in; end
      default:  begin nxt = ST_P0;                        obit = 1'b0;    end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          state <= ST_P0;
    else if (bit_vld) state <= nxt;
  end

  assign bit_out = bit_vld & obit;
  assign at_lsb  = (state == ST_P0);

  assert_reset_init_R1: assert property (@(posedge clk) rst |=> at_lsb);

  assert_gap_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(state));

  assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && (state == ST_P3_C0 || state == ST_P3_C1)) |=> at_lsb);

  assert_leave_lsb_R4: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && at_lsb) |=> !at_lsb);

  assert_idle_low_R5: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |-> !bit_out);

  assert_lsb_invert_R6: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && at_lsb) |-> (bit_out == !bit_in));

endmodule

// File: tb/tb_bcd_xs3_serial.sv
module tb_bcd_xs3_serial;
  logic clk = 1'b0;
  logic rst, bit_vld, bit_in;
  logic bit_out, at_lsb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_pos = 0;
  int m_acc = 0;
  int m_outacc = 0;

  bcd_xs3_serial dut (.clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
                      .bit_out(bit_out), .at_lsb(at_lsb));

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit r, bit v, bit b, string req);
    int exp_o;
    @(negedge clk);
    rst = r; bit_vld = v; bit_in = b;
    #2;
    if (r) begin
      m_pos = 0; m_acc = 0; m_outacc = 0;
      return;
    end
    if (v) begin
      exp_o = (((m_acc | (int'(b) << m_pos)) + 3) >> m_pos) & 1;
      chk({req, "/R6 bit"}, int'(bit_out), exp_o);
      chk("R4 at_lsb", int'(at_lsb), int'(m_pos == 0));
      m_outacc |= int'(bit_out) << m_pos;
      m_acc    |= int'(b) << m_pos;
      if (m_pos == 3) begin
        chk({req, " digit"}, m_outacc, (m_acc + 3) % 16);
        m_pos = 0; m_acc = 0; m_outacc = 0;
      end else m_pos++;
    end else begin
      chk("R5 idle out", int'(bit_out), 0);
      chk("R3 hold at_lsb", int'(at_lsb), int'(m_pos == 0));
    end
  endtask

  task automatic send_digit(int d, int gap, string req);
    for (int k = 0; k < 4; k++) begin
      step(0, 1, d[k], req);
      for (int g = 0; g < gap; g++) step(0, 0, ~d[k], "R3");
    end
  endtask

  initial begin
    rst = 1; bit_vld = 0; bit_in = 0;
    step(1, 0, 0, "R1");
    step(1, 0, 1, "R1");
    step(0, 0, 1, "R1");
    chk("R1 at_lsb after reset", int'(at_lsb), 1);
    chk("R1 out after reset", int'(bit_out), 0);

    for (int d = 0; d < 10; d++) send_digit(d, 0, "R2");
    for (int d = 9; d >= 0; d--) send_digit(d, (d % 3) + 1, "R2");

    for (int d = 10; d < 16; d++) send_digit(d, d % 2, "R7");

    step(0, 1, 1, "R2");
    step(0, 1, 1, "R2");
    step(1, 0, 0, "R1");
    step(0, 0, 0, "R1");
    chk("R1 mid-digit reset", int'(at_lsb), 1);
    send_digit(7, 0, "R2");
    send_digit(0, 2, "R2");

    @(negedge clk); bit_vld = 1; bit_in = 0; #2;
    chk("R6 lsb follows in=0", int'(bit_out), 1);
    bit_in = 1; #2;
    chk("R6 lsb follows in=1", int'(bit_out), 0);
    bit_vld = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule